// File: doc/BRIEF.md
# Flash Region Access Checker with Direct-Read Cache

This block sits between four bus masters and a flash read engine and decides, for every direct access, whether the master may touch flash at all. Each master presents a requester ID, a read/write flag and a byte address relative to its own region. The block compares the ID with the primary requester ID configured for that master. It turns the relative address into a flash linear address by adding the region base, and admits the access only when that address lies within the master's region. Writes are never admitted on this path. A refused access gets an error response with all-ones data and raises a sticky per-master violation flag.

Admitted reads are served from a single 64-byte line cache when the line and the owning master both match. Otherwise one line is fetched from the flash read engine, with never more than one fetch in flight. Whenever a read comes from a master other than the one that filled the cache, the cache empties itself to zero before anything else happens, so no master ever sees a line fetched for another. Masters hold their request until their response strobe and are served by fixed priority.

Top module: `fra_access_ctrl`

## Requirements
- R1: A request whose requester ID differs from the configured primary ID of that master is refused.
- R2: A refused request gets, in the cycle after the edge that accepts it, a response strobe on that master's bit with `rsp_err`=1 and `rsp_data`=32'hFFFFFFFF.
- R3: The linear address is base*4096 + relative address, where base and limit are 4 KB block numbers. The request is admitted only if base <= limit and the linear address <= limit*4096 + 4095. The last byte of the limit block is inside the region, and a region with limit < base refuses everything.
- R4: Any request with `req_wr`=1 is refused, whatever its ID or address.
- R5: An accepted read, admitted or refused, from a master other than the cache owner empties the cache, so the owner's next read of its cached line goes to flash. An accepted write from another master does not empty it.
- R6: An admitted read whose line address (linear address bits above 5) and master match the cached line responds in the cycle after acceptance with `rsp_err`=0, without raising `fl_req`.
- R7: `viol_sts[m]` is set by a refused request of master m and stays set until a cycle with `viol_clr[m]`=1. A set in the same cycle takes precedence over a clear.
- R8: When several masters request at once, the lowest index wins: 0 host firmware, 1 Ethernet, 2 management controller, 3 embedded controller. At most one `rsp_valid` bit is high in any cycle.
- R9: On a miss, `fl_req` stays high with `fl_addr` = linear address bits [ADDR_W-1:6] until `fl_valid`. The response follows in the next cycle and carries word (linear address bits [5:2]) of `fl_line`, where word i occupies bits 32i+31 down to 32i.
- R10: After reset, `rsp_valid`, `fl_req` and `viol_sts` are all zero and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NUM_MST | Per-master request, held until its response strobe |
| req_wr | input | NUM_MST | Per-master write flag |
| req_id | input | NUM_MST*ID_W | Per-master requester ID |
| req_addr | input | NUM_MST*ADDR_W | Per-master region-relative byte address |
| cfg_rid | input | NUM_MST*ID_W | Configured primary requester ID per master |
| cfg_base | input | NUM_MST*(ADDR_W-12) | Region base, 4 KB block number |
| cfg_limit | input | NUM_MST*(ADDR_W-12) | Region limit, 4 KB block number, inclusive |
| rsp_valid | output | NUM_MST | One-cycle response strobe per master |
| rsp_err | output | 1 | Response is a refusal |
| rsp_data | output | 32 | Response data word |
| fl_req | output | 1 | Line fetch request to the flash engine |
| fl_addr | output | ADDR_W-6 | Line address of the fetch |
| fl_valid | input | 1 | Fetched line is present on fl_line |
| fl_line | input | 512 | Fetched 64-byte line |
| viol_clr | input | NUM_MST | Clear strobe for the violation flags |
| viol_sts | output | NUM_MST | Sticky violation flags |

## Verification
A refusal and a cache hit both answer exactly one cycle after the edge that samples the request. A miss answers one cycle after the edge that sees `fl_valid`. With the bench's flash model replying three cycles after it observes `fl_req`, a miss therefore takes four cycles. The bench drives requests on the falling edge and counts falling edges until the response strobe appears, then compares that count with 1 or 4. That count also distinguishes hits from misses, alongside a tally of flash fetches. Violation flags and the emptying of the cache are probed through later responses and fetch counts, never through internal state.

// File: rtl/fra_pkg.sv
package fra_pkg;
  localparam int BLK_SHIFT  = 12;
  localparam int LINE_SHIFT = 6;
  localparam int WORD_W     = 32;
  localparam int LINE_BYTES = 1 << LINE_SHIFT;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int WORDS      = LINE_BYTES / 4;
  localparam int WSEL_W     = $clog2(WORDS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } fra_state_e;
endpackage

// File: rtl/fra_region_check.sv
module fra_region_check
  import fra_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int ID_W   = 8
) (
  input  logic [ADDR_W-BLK_SHIFT-1:0] base,
  input  logic [ADDR_W-BLK_SHIFT-1:0] limit,
  input  logic [ID_W-1:0]             rid_cfg,
  input  logic [ID_W-1:0]             rid_in,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           rel_addr,
  output logic [ADDR_W-3:0]           word_addr,
  output logic                        allow
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;

  function automatic logic [ADDR_W:0] to_linear(input logic [BLK_W-1:0] b,
                                                input logic [ADDR_W-1:0] rel);
    return {1'b0, b, {BLK_SHIFT{1'b0}}} + {1'b0, rel};
  endfunction

  function automatic logic [ADDR_W:0] region_top(input logic [BLK_W-1:0] l);
    return {1'b0, l, {BLK_SHIFT{1'b1}}};
  endfunction

  logic [ADDR_W:0] lin;
  logic            id_ok;
  logic            range_ok;

  always_comb begin
    lin       = to_linear(base, rel_addr);
    id_ok     = (rid_in == rid_cfg);
    range_ok  = (base <= limit) && (lin <= region_top(limit));
    allow     = id_ok && range_ok && !wr;
    word_addr = lin[ADDR_W-1:2];
  end
endmodule

// File: rtl/fra_arbiter.sv
module fra_arbiter #(
  parameter int NUM_MST = 4,
  localparam int IDX_W  = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic [NUM_MST-1:0] req,
  output logic [NUM_MST-1:0] gnt,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = NUM_MST - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
    gnt = any ? (NUM_MST'(1) << idx) : '0;
  end
endmodule

// File: rtl/fra_line_cache.sv
module fra_line_cache
  import fra_pkg::*;
#(
  parameter int TAG_W = 21,
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fill,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [IDX_W-1:0]  fill_owner,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic [IDX_W-1:0]  look_owner,
  input  logic [WSEL_W-1:0] look_wsel,
  output logic              hit,
  output logic [WORD_W-1:0] rd_word,
  output logic              valid_o,
  output logic [IDX_W-1:0]  owner_o
);
  logic              valid_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  owner_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      owner_q <= '0;
      line_q  <= '0;
    end else if (fill) begin
      valid_q <= 1'b1;
      tag_q   <= fill_tag;
      owner_q <= fill_owner;
      line_q  <= fill_line;
    end else if (clr) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      owner_q <= '0;
      line_q  <= '0;
    end
  end

  always_comb begin
    hit     = valid_q && (tag_q == look_tag) && (owner_q == look_owner);
    rd_word = line_q[look_wsel*WORD_W +: WORD_W];
    valid_o = valid_q;
    owner_o = owner_q;
  end
endmodule

// File: rtl/fra_access_ctrl.sv
module fra_access_ctrl
  import fra_pkg::*;
#(
  parameter int NUM_MST = 4,
  parameter int ADDR_W  = 27,
  parameter int ID_W    = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_MST-1:0]                   req_valid,
  input  logic [NUM_MST-1:0]                   req_wr,
  input  logic [NUM_MST*ID_W-1:0]              req_id,
  input  logic [NUM_MST*ADDR_W-1:0]            req_addr,
  input  logic [NUM_MST*ID_W-1:0]              cfg_rid,
  input  logic [NUM_MST*(ADDR_W-BLK_SHIFT)-1:0] cfg_base,
  input  logic [NUM_MST*(ADDR_W-BLK_SHIFT)-1:0] cfg_limit,
  output logic [NUM_MST-1:0]                   rsp_valid,
  output logic                                 rsp_err,
  output logic [WORD_W-1:0]                    rsp_data,
  output logic                                 fl_req,
  output logic [ADDR_W-LINE_SHIFT-1:0]         fl_addr,
  input  logic                                 fl_valid,
  input  logic [LINE_W-1:0]                    fl_line,
  input  logic [NUM_MST-1:0]                   viol_clr,
  output logic [NUM_MST-1:0]                   viol_sts
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;
  localparam int TAG_W = ADDR_W - LINE_SHIFT;
  localparam int WA_W  = ADDR_W - 2;
  localparam int IDX_W = (NUM_MST > 1) ? $clog2(NUM_MST) : 1;

  // per-master protection checks
  logic [NUM_MST-1:0] allow_v;
  logic [WA_W-1:0]    wa_v [NUM_MST];

  for (genvar g = 0; g < NUM_MST; g++) begin : g_chk
    fra_region_check #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
      .base      (cfg_base [g*BLK_W  +: BLK_W]),
      .limit     (cfg_limit[g*BLK_W  +: BLK_W]),
      .rid_cfg   (cfg_rid  [g*ID_W   +: ID_W]),
      .rid_in    (req_id   [g*ID_W   +: ID_W]),
      .wr        (req_wr[g]),
      .rel_addr  (req_addr [g*ADDR_W +: ADDR_W]),
      .word_addr (wa_v[g]),
      .allow     (allow_v[g])
    );
  end

  // arbitration
  fra_state_e         state_q;
  logic [NUM_MST-1:0] arb_req;
  logic [NUM_MST-1:0] arb_gnt;
  logic [IDX_W-1:0]   arb_idx;
  logic               arb_any;

  assign arb_req = (state_q == ST_IDLE) ? req_valid : '0;

  fra_arbiter #(.NUM_MST(NUM_MST)) u_arb (
    .req (arb_req),
    .gnt (arb_gnt),
    .idx (arb_idx),
    .any (arb_any)
  );

  // selected request and named events
  logic            acc_ev;
  logic            acc_wr_ev;
  logic            sel_allow;
  logic [WA_W-1:0] sel_wa;
  logic            deny_ev;
  logic            hit_ev;
  logic            miss_ev;
  logic            clr_ev;
  logic            fill_ev;

  logic              cache_hit;
  logic [WORD_W-1:0] cache_word;
  logic              cache_valid;
  logic [IDX_W-1:0]  cache_owner;

  logic [NUM_MST-1:0] gnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [WA_W-1:0]    wa_q;

  always_comb begin
    acc_ev    = arb_any;
    sel_allow = allow_v[arb_idx];
    sel_wa    = wa_v[arb_idx];
    acc_wr_ev = acc_ev && req_wr[arb_idx];
    deny_ev   = acc_ev && !sel_allow;
    hit_ev    = acc_ev && sel_allow && cache_hit;
    miss_ev   = acc_ev && sel_allow && !cache_hit;
    clr_ev    = acc_ev && !req_wr[arb_idx] && cache_valid && (arb_idx != cache_owner);
    fill_ev   = (state_q == ST_WAIT) && fl_valid;
  end

  fra_line_cache #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_ev),
    .fill       (fill_ev),
    .fill_tag   (wa_q[WA_W-1:WSEL_W]),
    .fill_owner (idx_q),
    .fill_line  (fl_line),
    .look_tag   (sel_wa[WA_W-1:WSEL_W]),
    .look_owner (arb_idx),
    .look_wsel  (sel_wa[WSEL_W-1:0]),
    .hit        (cache_hit),
    .rd_word    (cache_word),
    .valid_o    (cache_valid),
    .owner_o    (cache_owner)
  );

  // control sequence and response registers
  logic [NUM_MST-1:0] rsp_valid_q;
  logic               rsp_err_q;
  logic [WORD_W-1:0]  rsp_data_q;
  logic [WORD_W-1:0]  fl_word;

  assign fl_word = fl_line[wa_q[WSEL_W-1:0]*WORD_W +: WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      gnt_q       <= '0;
      idx_q       <= '0;
      wa_q        <= '0;
      rsp_valid_q <= '0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (acc_ev) begin
            gnt_q <= arb_gnt;
            idx_q <= arb_idx;
            wa_q  <= sel_wa;
            if (deny_ev) begin
              rsp_valid_q <= arb_gnt;
              rsp_err_q   <= 1'b1;
              rsp_data_q  <= '1;
              state_q     <= ST_RESP;
            end else if (hit_ev) begin
              rsp_valid_q <= arb_gnt;
              rsp_err_q   <= 1'b0;
              rsp_data_q  <= cache_word;
              state_q     <= ST_RESP;
            end else if (miss_ev) begin
              state_q     <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (fl_valid) begin
            rsp_valid_q <= gnt_q;
            rsp_err_q   <= 1'b0;
            rsp_data_q  <= fl_word;
            state_q     <= ST_RESP;
          end
        end
        ST_RESP: begin
          rsp_valid_q <= '0;
          rsp_err_q   <= 1'b0;
          rsp_data_q  <= '0;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // sticky violation flags: set beats clear
  logic [NUM_MST-1:0] viol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= '0;
    else        viol_q <= (viol_q & ~viol_clr) | (deny_ev ? arb_gnt : '0);
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_data  = rsp_data_q;
  assign fl_req    = (state_q == ST_WAIT);
  assign fl_addr   = wa_q[WA_W-1:WSEL_W];
  assign viol_sts  = viol_q;
endmodule

// File: rtl/fra_access_sva.sv
module fra_access_sva #(
  parameter int NUM_MST = 4,
  parameter int ADDR_W  = 27
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_ev,
  input logic                  acc_wr_ev,
  input logic                  hit_ev,
  input logic                  clr_ev,
  input logic                  cache_valid,
  input logic [NUM_MST-1:0]    arb_gnt,
  input logic [NUM_MST-1:0]    req_valid,
  input logic [NUM_MST-1:0]    rsp_valid,
  input logic                  rsp_err,
  input logic [31:0]           rsp_data,
  input logic                  fl_req,
  input logic                  fl_valid,
  input logic [ADDR_W-7:0]     fl_addr,
  input logic [NUM_MST-1:0]    viol_clr,
  input logic [NUM_MST-1:0]    viol_sts
);
  a_r4_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && acc_wr_ev) |=> (rsp_err && (rsp_valid != '0)));

  a_r2_refusal_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    ((rsp_valid != '0) && rsp_err) |-> (rsp_data == 32'hFFFF_FFFF));

  a_r8_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_gnt != '0) |-> ((req_valid & (arb_gnt - NUM_MST'(1))) == '0));

  a_r6_hit_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> (!fl_req && (rsp_valid != '0) && !rsp_err));

  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> !cache_valid);

  a_r9_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_valid) |=> (fl_req && $stable(fl_addr)));

  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~viol_sts & $past(viol_sts) & ~$past(viol_clr)) == '0));
endmodule

bind fra_access_ctrl fra_access_sva #(.NUM_MST(NUM_MST), .ADDR_W(ADDR_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_ev      (acc_ev),
  .acc_wr_ev   (acc_wr_ev),
  .hit_ev      (hit_ev),
  .clr_ev      (clr_ev),
  .cache_valid (cache_valid),
  .arb_gnt     (arb_gnt),
  .req_valid   (req_valid),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .rsp_data    (rsp_data),
  .fl_req      (fl_req),
  .fl_valid    (fl_valid),
  .fl_addr     (fl_addr),
  .viol_clr    (viol_clr),
  .viol_sts    (viol_sts)
);

// File: tb/test_fra_access_ctrl.sv
`timescale 1ns/1ps
module test_fra_access_ctrl;
  localparam int N   = 4;
  localparam int AW  = 27;
  localparam int IW  = 8;
  localparam int BW  = AW - 12;
  localparam int LAT = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_wr = '0;
  logic [N*IW-1:0] req_id = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*IW-1:0] cfg_rid;
  logic [N*BW-1:0] cfg_base;
  logic [N*BW-1:0] cfg_limit;
  logic [N-1:0]    rsp_valid;
  logic            rsp_err;
  logic [31:0]     rsp_data;
  logic            fl_req;
  logic [AW-7:0]   fl_addr;
  logic            fl_valid = 1'b0;
  logic [511:0]    fl_line = '0;
  logic [N-1:0]    viol_clr = '0;
  logic [N-1:0]    viol_sts;

  always #2.5 clk = ~clk;

  fra_access_ctrl #(.NUM_MST(N), .ADDR_W(AW), .ID_W(IW)) i_fra_access_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_id(req_id), .req_addr(req_addr), .cfg_rid(cfg_rid),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data), .fl_req(fl_req),
    .fl_addr(fl_addr), .fl_valid(fl_valid), .fl_line(fl_line),
    .viol_clr(viol_clr), .viol_sts(viol_sts)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_fetch = 0;

  logic [31:0] got_data;
  logic        got_err;
  int          got_wait;
  int          got_idx;

  // expected content of word i of line l
  function automatic logic [31:0] mk(input logic [AW-7:0] l, input logic [3:0] i);
    return {7'h5A, l, i};
  endfunction

  function automatic logic [AW-1:0] lin(input int m, input logic [AW-1:0] rel);
    return {cfg_base[m*BW +: BW], 12'h000} + rel;
  endfunction

  function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
    return mk(a[AW-1:6], a[5:2]);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash engine model: answers LAT cycles after it sees fl_req
  initial begin
    forever begin
      @(negedge clk);
      if (fl_req && !fl_valid) begin
        repeat (LAT - 1) @(negedge clk);
        for (int i = 0; i < 16; i++) fl_line[i*32 +: 32] = mk(fl_addr, 4'(i));
        fl_valid = 1'b1;
        n_fetch++;
        @(negedge clk);
        fl_valid = 1'b0;
      end
    end
  end

  task automatic set_req(input int m, input logic [7:0] id, input logic wr, input logic [AW-1:0] a);
    req_id[m*IW +: IW]   = id;
    req_wr[m]            = wr;
    req_addr[m*AW +: AW] = a;
    req_valid[m]         = 1'b1;
  endtask

  task automatic wait_rsp(input logic [N-1:0] mask);
    got_wait = 0;
    got_idx  = -1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      got_wait++;
      if ((rsp_valid & mask) != '0) begin
        for (int j = 0; j < N; j++) if (rsp_valid[j]) got_idx = j;
        got_err  = rsp_err;
        got_data = rsp_data;
        req_valid[got_idx] = 1'b0;
        return;
      end
    end
    chk(1'b0, "response timeout", 0, 1);
  endtask

  task automatic one(input int m, input logic [7:0] id, input logic wr, input logic [AW-1:0] a);
    @(negedge clk);
    set_req(m, id, wr, a);
    wait_rsp(N'(1) << m);
  endtask

  function automatic logic [7:0] rid(input int m);
    return cfg_rid[m*IW +: IW];
  endfunction

  task automatic t_reset;
    chk(rsp_valid == '0, "R10 rsp_valid after reset", 64'(rsp_valid), 0);
    chk(fl_req == 1'b0, "R10 fl_req after reset", 64'(fl_req), 0);
    chk(viol_sts == '0, "R10 viol_sts after reset", 64'(viol_sts), 0);
  endtask

  task automatic t_miss_hit;
    int f0;
    f0 = n_fetch;
    one(0, rid(0), 1'b0, 27'h1234);
    chk(!got_err && got_data == exp_word(lin(0, 27'h1234)), "R9 R3 miss data", 64'(got_data), 64'(exp_word(lin(0, 27'h1234))));
    chk(got_wait == 1 + LAT && n_fetch == f0 + 1, "R9 miss latency", 64'(got_wait), 64'(1 + LAT));
    one(0, rid(0), 1'b0, 27'h1238);
    chk(!got_err && got_data == exp_word(lin(0, 27'h1238)), "R6 hit data", 64'(got_data), 64'(exp_word(lin(0, 27'h1238))));
    chk(got_wait == 1 && n_fetch == f0 + 1, "R6 hit one cycle no fetch", 64'(got_wait), 1);
  endtask

  task automatic t_bad_id;
    one(0, rid(0) ^ 8'h01, 1'b0, 27'h1234);
    chk(got_err && got_data == 32'hFFFF_FFFF && got_wait == 1, "R1 R2 wrong id refused", 64'(got_data), 64'hFFFF_FFFF);
    chk(viol_sts == 4'b0001, "R7 sticky set", 64'(viol_sts), 1);
    repeat (3) @(negedge clk);
    chk(viol_sts == 4'b0001, "R7 sticky held", 64'(viol_sts), 1);
    viol_clr = 4'b0001;
    @(negedge clk);
    viol_clr = '0;
    chk(viol_sts == '0, "R7 cleared", 64'(viol_sts), 0);
  endtask

  task automatic t_write;
    int f0;
    f0 = n_fetch;
    one(1, rid(1), 1'b1, 27'h0010);
    chk(got_err && got_data == 32'hFFFF_FFFF && n_fetch == f0, "R4 write refused", 64'(got_err), 1);
    chk(viol_sts == 4'b0010, "R4 R7 write flags Ethernet", 64'(viol_sts), 2);
    viol_clr = 4'b0010;
    @(negedge clk);
    viol_clr = '0;
  endtask

  task automatic t_limits;
    one(1, rid(1), 1'b0, 27'h1FFF);
    chk(!got_err && got_data == exp_word(lin(1, 27'h1FFF)), "R3 last byte of limit block", 64'(got_data), 64'(exp_word(lin(1, 27'h1FFF))));
    one(1, rid(1), 1'b0, 27'h2000);
    chk(got_err && got_data == 32'hFFFF_FFFF, "R3 one past limit refused", 64'(got_err), 1);
    cfg_limit[3*BW +: BW] = 15'h1FF;
    one(3, rid(3), 1'b0, 27'h0000);
    chk(got_err, "R3 limit below base disables", 64'(got_err), 1);
    cfg_limit[3*BW +: BW] = 15'h20F;
    one(3, rid(3), 1'b0, 27'h0000);
    chk(!got_err && got_data == exp_word(lin(3, 0)), "R3 restored region", 64'(got_data), 64'(exp_word(lin(3, 0))));
    viol_clr = '1;
    @(negedge clk);
    viol_clr = '0;
  endtask

  task automatic t_cache_clear;
    int f0;
    one(0, rid(0), 1'b0, 27'h4000);
    f0 = n_fetch;
    one(1, rid(1), 1'b1, 27'h0000);
    one(0, rid(0), 1'b0, 27'h4004);
    chk(!got_err && got_wait == 1 && n_fetch == f0, "R5 write from other master keeps line", 64'(got_wait), 1);
    one(2, rid(2) ^ 8'h80, 1'b0, 27'h0000);
    chk(got_err, "R5 refused read from other master", 64'(got_err), 1);
    one(0, rid(0), 1'b0, 27'h4008);
    chk(got_wait == 1 + LAT && n_fetch == f0 + 1, "R5 other read empties cache", 64'(got_wait), 64'(1 + LAT));
    chk(got_data == exp_word(lin(0, 27'h4008)), "R5 refetched data", 64'(got_data), 64'(exp_word(lin(0, 27'h4008))));
    viol_clr = '1;
    @(negedge clk);
    viol_clr = '0;
  endtask

  task automatic t_priority;
    @(negedge clk);
    set_req(3, rid(3), 1'b1, 27'h0);
    set_req(1, rid(1), 1'b1, 27'h0);
    wait_rsp('1);
    chk(got_idx == 1, "R8 Ethernet before embedded controller", 64'(got_idx), 1);
    chk($countones(rsp_valid) == 1, "R8 single strobe", 64'(rsp_valid), 2);
    wait_rsp('1);
    chk(got_idx == 3, "R8 embedded controller served second", 64'(got_idx), 3);
    @(negedge clk);
    set_req(2, rid(2), 1'b1, 27'h0);
    set_req(0, rid(0), 1'b1, 27'h0);
    wait_rsp('1);
    chk(got_idx == 0, "R8 host firmware first", 64'(got_idx), 0);
    wait_rsp('1);
    chk(got_idx == 2, "R8 management controller second", 64'(got_idx), 2);
    viol_clr = '1;
    @(negedge clk);
    viol_clr = '0;
  endtask

  initial begin
    cfg_rid   = {8'h40, 8'h30, 8'h20, 8'h10};
    cfg_base  = {15'h200, 15'h010, 15'h003, 15'h100};
    cfg_limit = {15'h20F, 15'h0FF, 15'h004, 15'h1FF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_bad_id();
    t_write();
    t_limits();
    t_cache_clear();
    t_priority();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule